// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Register Front End

This block is the bus-facing register window of a one-time-programmable fuse macro. A simple 32-bit word bus (select, write enable, 12-bit byte address, write data, registered read data) reaches a bank of fifteen word registers. Fourteen of them are plain control registers: fuse address, I/O, address strobe, chip enable, clock, data in, data strobe, program, test control, test mode, test mode repeat, test read, trim and write enable. The fifteenth is the read-only data-out port of the fuse array.

The fuse array has 4096 words of 32 bits. Bus writes never change its content. After reset every word reads as all ones, except for one pair of words that carries a serial number (a module parameter) and its bitwise complement. Software reads the serial number this way: it sets the fuse address, raises the enable bit of chip enable, data strobe and trim, and then reads data-out. While any of the three enable bits is low, data-out reads as a fixed 0x000000FF. Accesses to offsets outside the window read as zero. A write to such an offset changes nothing and raises a one-cycle error pulse.

Top module: `otp_fuse_regif`

## Requirements
- R1: While `rst_n` is low at a clock edge, every control register clears to 0, and `bus_rdata` and `bus_err` go to 0.
- R2: The control registers at word offsets 0x04, 0x08, 0x0C, 0x10, 0x14, 0x1C, 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34 and 0x38 store all 32 written bits and read them back unchanged.
- R3: The fuse address register at offset 0x00 keeps only bits 11:0 of a write. Bits 31:12 read back as 0.
- R4: A read of data-out (offset 0x18) returns the fuse word indexed by the fuse address register when bit 0 of chip enable (0x0C), bit 0 of data strobe (0x1C) and bit 0 of trim (0x34) are all 1.
- R5: If any one of those three bits is 0, a read of data-out returns 0x000000FF, whatever the other bits of those registers hold.
- R6: Fuse word 0x0FC holds the `SERIAL` parameter, word 0x0FD holds its bitwise complement, and every other word, including 0x000 and 0xFFF, holds 0xFFFFFFFF.
- R7: A write to data-out changes no register and no fuse word, and raises no error.
- R8: A read at an unmapped address returns 0. Unmapped means word offset 0x3C or above, or an address whose bits 1:0 are not 00.
- R9: A write to an unmapped address changes no register and sets `bus_err` to 1 for exactly the one cycle after the write. `bus_err` is 0 at all other times.
- R10: Read data is registered. It appears on `bus_rdata` one clock after the read request and holds through idle and write cycles until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read (valid with `bus_sel`) |
| bus_addr | input | 12 | Byte address inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse after a write to an unmapped address |

## Verification
The fuse readout is tried with the three enable bits all set, and then with each bit cleared in turn while the other bits of that register stay high. This shows that the gate uses bit 0 of every register and not a wider field. The fuse address is moved across the serial word, its complement, a neighbouring word and both ends of the array, which separates the two parameter-loaded words from the all-ones fill and from address aliasing. The control registers take distinct 32-bit patterns so that a swapped decode or a truncated store reads back wrong. Writes to data-out, to addresses past the last register and to a misaligned address that would alias chip enable are followed by reads. These reads show that nothing moved, that the error pulse comes only for the unmapped cases, and that registered read data holds between reads.

// File: rtl/otp_pkg.sv
// Package: shared constants and register index type for the fuse array
// register front end. Assumes one 32-bit register per word offset,
// starting at offset 0 and packed without gaps.
package otp_pkg;

    // Word index of each register (byte offset = index * 4).
    typedef enum logic [3:0] {
        IDX_ADDR  = 4'd0,
        IDX_IO    = 4'd1,
        IDX_ASTB  = 4'd2,
        IDX_CE    = 4'd3,
        IDX_CLK   = 4'd4,
        IDX_DIN   = 4'd5,
        IDX_DOUT  = 4'd6,
        IDX_DSTB  = 4'd7,
        IDX_PROG  = 4'd8,
        IDX_TCTL  = 4'd9,
        IDX_TMODE = 4'd10,
        IDX_TREP  = 4'd11,
        IDX_TRD   = 4'd12,
        IDX_TRIM  = 4'd13,
        IDX_WEN   = 4'd14
    } reg_idx_e;

    localparam int NUM_REGS  = 15;
    localparam int REG_IDX_W = $clog2(NUM_REGS);
    localparam int EN_BIT    = 0;
    localparam logic [31:0] CLOSED_VALUE = 32'h0000_00FF;

endpackage

// File: rtl/otp_addr_decode.sv
// Module: otp_addr_decode
// Turns a byte address into a register hit flag and a word index.
// Assumes word-only access: any address with nonzero low two bits misses.
module otp_addr_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit,
    output logic [REG_IDX_W-1:0] idx
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(NUM_REGS - 1);

    logic [WORD_W-1:0] word;

    // Split the address and compare the word index with the last register.
    always_comb begin
        word = addr[ADDR_W-1:2];
        hit  = (addr[1:0] == 2'b00) && (word <= LAST_WORD);
        idx  = word[REG_IDX_W-1:0];
    end
endmodule

// File: rtl/otp_ctrl_regs.sv
// Module: otp_ctrl_regs
// Control register bank. One register per index, generated. The fuse
// address slot keeps only FUSE_AW bits, and the data-out slot has no
// storage (it reads as zero here and is replaced later in the read path).
// Assumes wr_en is already qualified by a decode hit.
module otp_ctrl_regs
    import otp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FUSE_AW = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [REG_IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
    localparam logic [DATA_W-1:0] ADDR_KEEP = {{(DATA_W-FUSE_AW){1'b0}}, {FUSE_AW{1'b1}}};

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == int'(IDX_DOUT)) begin : g_ro
            // Data-out has no storage: writes to it go nowhere.
            assign regs_q[i] = '0;
        end else begin : g_rw
            localparam logic [DATA_W-1:0] KEEP = (i == int'(IDX_ADDR)) ? ADDR_KEEP : '1;
            // Store the masked write value when this register is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[i] <= '0;
                else if (wr_en && (wr_idx == REG_IDX_W'(i)))
                    regs_q[i] <= wdata & KEEP;
            end
        end
    end
endmodule

// File: rtl/otp_fuse_rom.sv
// Module: otp_fuse_rom
// Fuse array content as a function of the index. Bus writes never change
// the fuses, so the array reads as all ones except for the serial word and
// its complement at the next index. No storage is built.
module otp_fuse_rom #(
    parameter int                DATA_W     = 32,
    parameter int                FUSE_AW    = 12,
    parameter logic [DATA_W-1:0] SERIAL     = '0,
    parameter logic [FUSE_AW-1:0] SERIAL_IDX = 12'h0FC
) (
    input  logic [FUSE_AW-1:0] idx,
    output logic [DATA_W-1:0]  word
);
    localparam logic [FUSE_AW-1:0] CHECK_IDX = SERIAL_IDX + 1'b1;

    // Select the serial word, its check word or the blank fuse value.
    always_comb begin
        if (idx == SERIAL_IDX)
            word = SERIAL;
        else if (idx == CHECK_IDX)
            word = ~SERIAL;
        else
            word = '1;
    end
endmodule

// File: rtl/otp_rd_path.sv
// Module: otp_rd_path
// Registered read data and write error pulse. Data-out is gated by the
// enable bit of chip enable, data strobe and trim. Assumes rd_req and
// wr_req are never both high.
module otp_rd_path
    import otp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_req,
    input  logic                             wr_req,
    input  logic                             hit,
    input  logic [REG_IDX_W-1:0]             idx,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
    input  logic [DATA_W-1:0]                fuse_word,
    output logic [DATA_W-1:0]                rdata,
    output logic                             err
);
    logic              fuse_open;
    logic [DATA_W-1:0] rd_next;

    // Readout gate and the read data mux.
    always_comb begin
        fuse_open = regs_q[IDX_CE][EN_BIT] & regs_q[IDX_DSTB][EN_BIT]
                  & regs_q[IDX_TRIM][EN_BIT];
        if (!hit)
            rd_next = '0;
        else if (idx == IDX_DOUT)
            rd_next = fuse_open ? fuse_word : DATA_W'(CLOSED_VALUE);
        else
            rd_next = regs_q[idx];
    end

    // Capture read data on a read, and flag unmapped writes for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            if (rd_req)
                rdata <= rd_next;
            err <= wr_req && !hit;
        end
    end
endmodule

// File: rtl/otp_fuse_regif.sv
// Module: otp_fuse_regif (top)
// Register front end of a one-time-programmable fuse array: decode,
// control register bank, computed fuse content, registered read path.
// Assumes a single-cycle word bus with no wait states.
module otp_fuse_regif
    import otp_pkg::*;
#(
    parameter int                 ADDR_W     = 12,
    parameter int                 DATA_W     = 32,
    parameter int                 FUSE_AW    = 12,
    parameter logic [DATA_W-1:0]  SERIAL     = '0,
    parameter logic [FUSE_AW-1:0] SERIAL_IDX = 12'h0FC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err
);
    logic                            hit;
    logic [REG_IDX_W-1:0]            idx;
    logic                            rd_req;
    logic                            wr_req;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [DATA_W-1:0]               fuse_word;

    // Split the request into read and write strobes.
    always_comb begin
        rd_req = bus_sel && !bus_we;
        wr_req = bus_sel && bus_we;
    end

    otp_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx)
    );

    otp_ctrl_regs #(.DATA_W(DATA_W), .FUSE_AW(FUSE_AW)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_req && hit),
        .wr_idx (idx),
        .wdata  (bus_wdata),
        .regs_q (regs_q)
    );

    otp_fuse_rom #(
        .DATA_W(DATA_W), .FUSE_AW(FUSE_AW),
        .SERIAL(SERIAL), .SERIAL_IDX(SERIAL_IDX)
    ) rom_i (
        .idx  (regs_q[IDX_ADDR][FUSE_AW-1:0]),
        .word (fuse_word)
    );

    otp_rd_path #(.DATA_W(DATA_W)) rd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .hit       (hit),
        .idx       (idx),
        .regs_q    (regs_q),
        .fuse_word (fuse_word),
        .rdata     (bus_rdata),
        .err       (bus_err)
    );
endmodule

// File: rtl/otp_fuse_regif_chk.sv
// Module: otp_fuse_regif_chk
// Port-level temporal checks for otp_fuse_regif, attached with bind.
module otp_fuse_regif_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err
);
    logic outside;

    // Address outside the fifteen-word window, or misaligned.
    always_comb outside = (bus_addr[1:0] != 2'b00) || (bus_addr >= ADDR_W'(60));

    // R1: reset clears the outputs.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (bus_rdata == '0 && !bus_err));

    // R8: unmapped read returns zero.
    assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && outside) |=> (bus_rdata == '0));

    // R9: unmapped write pulses the error flag.
    assert_err_after_bad_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && outside) |=> bus_err);

    // R9: no error without an unmapped write.
    assert_no_spurious_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we && outside) |=> !bus_err);

    // R10: read data holds when no read is made.
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> $stable(bus_rdata));
endmodule

bind otp_fuse_regif otp_fuse_regif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err)
);

// File: tb/otp_fuse_regif_tb_top.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor pops
// and compares it on the cycle after each read.
module otp_fuse_regif_tb_top;
    localparam logic [31:0] SER = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    logic [31:0] last_rd = '0;

    always #10 clk = ~clk; // 50 MHz

    otp_fuse_regif #(.SERIAL(SER)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: note reads at the edge, compare away from the edge.
    always @(posedge clk) rd_seen <= bus_sel && !bus_we && rst_n;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard empty", bus_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
                last_rd = e;
            end
        end
    end

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit exp_err, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        check(bus_err === exp_err, tag, 32'(bus_err), 32'(exp_err));
        check(bus_rdata === last_rd, "R10 hold over write", bus_rdata, last_rd);
        @(negedge clk);
        if (exp_err) check(bus_err === 1'b0, {tag, " pulse width"}, 32'(bus_err), 32'h0);
    endtask

    task automatic open_gate();
        wr(12'h00C, 32'h0000_0001, 1'b0, "R4 ce");
        wr(12'h01C, 32'h0000_0001, 1'b0, "R4 dstb");
        wr(12'h034, 32'h0000_0001, 1'b0, "R4 trim");
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs clear in reset.
        check(bus_rdata === 32'h0, "R1 rdata in reset", bus_rdata, 32'h0);
        check(bus_err === 1'b0, "R1 err in reset", 32'(bus_err), 32'h0);
        rst_n = 1'b1;

        // R1: all registers 0; R5: data-out closed reads 0xFF.
        for (int i = 0; i < 15; i++)
            rd(12'(i * 4), (i == 6) ? 32'h0000_00FF : 32'h0, (i == 6) ? "R5 dout after reset" : "R1 reg after reset");

        // R2: full-width store and readback.
        for (int i = 1; i < 15; i++)
            if (i != 6) wr(12'(i * 4), 32'hA500_0000 ^ (32'(i) * 32'h0101_0111), 1'b0, "R2 write");
        for (int i = 1; i < 15; i++)
            if (i != 6) rd(12'(i * 4), 32'hA500_0000 ^ (32'(i) * 32'h0101_0111), "R2 readback");

        // R3: address register keeps 12 bits.
        wr(12'h000, 32'hFFFF_F0FC, 1'b0, "R3 write");
        rd(12'h000, 32'h0000_00FC, "R3 readback");

        // R7: write to data-out with gate closed (trim bit 0 pattern).
        wr(12'h034, 32'h0, 1'b0, "R5 trim off");
        wr(12'h018, 32'hDEAD_BEEF, 1'b0, "R7 dout write no err");
        rd(12'h018, 32'h0000_00FF, "R7 dout closed after write");

        // R4/R6: open gate and walk the fuse indices.
        open_gate();
        rd(12'h018, SER, "R6 serial word");
        wr(12'h000, 32'h0000_00FD, 1'b0, "R4 addr");
        rd(12'h018, ~SER, "R6 check word");
        wr(12'h000, 32'h0000_00FB, 1'b0, "R4 addr");
        rd(12'h018, 32'hFFFF_FFFF, "R6 blank near serial");
        wr(12'h000, 32'h0000_0000, 1'b0, "R4 addr");
        rd(12'h018, 32'hFFFF_FFFF, "R6 blank word 0");
        wr(12'h000, 32'h0000_0FFF, 1'b0, "R4 addr");
        rd(12'h018, 32'hFFFF_FFFF, "R6 blank last word");
        wr(12'h000, 32'h0000_10FC, 1'b0, "R3 alias addr");
        rd(12'h018, SER, "R3 R4 masked index reads serial");

        // R7: write to data-out with gate open leaves the fuses alone.
        wr(12'h018, 32'h0000_0000, 1'b0, "R7 dout write open");
        rd(12'h018, SER, "R7 serial unchanged");

        // R5: clear each enable bit with the other bits high.
        wr(12'h00C, 32'hFFFF_FFFE, 1'b0, "R5 ce bit0 off");
        rd(12'h018, 32'h0000_00FF, "R5 ce closed");
        open_gate();
        wr(12'h01C, 32'hFFFF_FFFE, 1'b0, "R5 dstb bit0 off");
        rd(12'h018, 32'h0000_00FF, "R5 dstb closed");
        open_gate();
        wr(12'h034, 32'hFFFF_FFFE, 1'b0, "R5 trim bit0 off");
        rd(12'h018, 32'h0000_00FF, "R5 trim closed");
        open_gate();

        // R8: unmapped reads.
        rd(12'h03C, 32'h0, "R8 first past window");
        rd(12'hFFC, 32'h0, "R8 top of window");
        rd(12'h00D, 32'h0, "R8 misaligned");

        // R9: unmapped writes raise error and change nothing.
        wr(12'h03C, 32'h1234_0000, 1'b1, "R9 err past window");
        wr(12'h00D, 32'h0000_0000, 1'b1, "R9 err misaligned ce");
        wr(12'h002, 32'h0000_0000, 1'b1, "R9 err misaligned addr");
        rd(12'h00C, 32'h0000_0001, "R9 ce unchanged");
        rd(12'h000, 32'h0000_00FC, "R9 addr unchanged");
        rd(12'h018, SER, "R9 gate still open");

        // R10: read data holds through idle cycles.
        repeat (3) @(negedge clk);
        check(bus_rdata === SER, "R10 hold idle", bus_rdata, SER);

        // R1: reset again clears registers.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(bus_rdata === 32'h0, "R1 rdata re-reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        last_rd = 32'h0;
        rd(12'h00C, 32'h0, "R1 ce after re-reset");
        rd(12'h018, 32'h0000_00FF, "R1 dout closed after re-reset");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule